// File: doc/BRIEF.md
# Instruction Line Fetch Request Controller

This block sits at the front of an instruction fetch stage that serves several hardware threads. Each cycle it may receive one fetch attempt: a thread number, a fetch address and a one-cycle translation fault flag. It rounds the address down to the start of a cache line. It then compares that line with a small per-thread line buffer tag. A match satisfies the fetch at once. A miss launches a line read on a valid/ready request port, unless the translation faulted.

A refused read stays in a single retry slot that all threads share. While it waits there, a global blocked flag stops every new request. The slot is presented again until the port takes it. Each thread carries a state (running, waiting for a response, waiting for a retry, squashing) and a small generation number that is stamped on its requests. A per-thread squash cancels that thread's outstanding work and advances its generation. A late response from before the squash is therefore recognised and dropped. Fetching can also be held off globally, by a switched-out input or by a pending interrupt when the two low address bits are zero. Line contents are not handled here, only the bookkeeping of which line each thread holds.

Top module: `ifl_fetch_req`

## Requirements
- R1: The request address is the fetch address with its low log2(LINE_BYTES) bits forced to zero; req_tid and req_gen carry the issuing thread and its current generation.
- R2: While cache_blocked is 1, switched_out is 1, or intr_pending is 1 with fetch address bits [1:0] equal to 2'b00, a fetch attempt starts no request, changes no thread state and gives fe_stall=1 one cycle later.
- R3: When the thread's buffer is valid and its stored line equals the aligned fetch address, the fetch gives fe_hit=1 one cycle later and starts no request.
- R4: A miss without fault loads the retry slot, so req_valid=1 on the next cycle; that thread's buffer valid bit goes to 0, its stored line takes the new line, and its state becomes wait-response (encoding 1).
- R5: A miss with fe_xlate_fault=1 gives fe_fault=1 one cycle later, starts no request and leaves the thread state and buffer unchanged.
- R6: When req_valid=1 and req_ready=0, the request is held unchanged, cache_blocked becomes 1 and the owning thread enters wait-retry (encoding 2).
- R7: When a held request sees req_ready=1, req_valid and cache_blocked both fall on the next cycle and the owning thread's state becomes wait-response (encoding 1).
- R8: A squash of a thread sets its state to squashing (encoding 3), increments its generation when it was not already squashing, and clears the retry slot and cache_blocked if the slot belongs to that thread. The state returns to running (encoding 0) on the first cycle after squash falls.
- R9: A response whose thread is in wait-response and whose generation equals the thread's current one sets that thread's buffer valid bit and its state to running. Any other response changes nothing.
- R10: A fetch attempt for a thread that is not running, or whose squash input is 1, gives fe_stall=1 and has no other effect.
- R11: After reset no request is valid, cache_blocked is 0, every thread is running with generation 0, every buffer is invalid and fe_hit, fe_fault and fe_stall are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | Fetch attempt present this cycle |
| fe_tid | input | TIDW | Thread of the fetch attempt |
| fe_pc | input | AW | Fetch address |
| fe_xlate_fault | input | 1 | Translation of this fetch faulted |
| intr_pending | input | 1 | Interrupt waiting to be taken |
| switched_out | input | 1 | Fetch stage is switched out |
| squash | input | NTHR | Per-thread squash |
| req_valid | output | 1 | Line read request valid |
| req_addr | output | AW | Line-aligned request address |
| req_tid | output | TIDW | Requesting thread |
| req_gen | output | GENW | Requesting thread's generation |
| req_ready | input | 1 | Request port accepts this cycle |
| rsp_valid | input | 1 | Line read response present |
| rsp_tid | input | TIDW | Thread of the response |
| rsp_gen | input | GENW | Generation echoed by the response |
| fe_hit | output | 1 | Previous fetch hit the line buffer |
| fe_fault | output | 1 | Previous fetch faulted in translation |
| fe_stall | output | 1 | Previous fetch was held off |
| cache_blocked | output | 1 | A refused request occupies the retry slot |
| thr_state | output | 2*NTHR | Per-thread state, two bits per thread |
| buf_valid | output | NTHR | Per-thread line buffer valid |

## Verification
The assertions assume that a response arrives only for a request the port has already taken, at most once per request, with rsp_tid below NTHR, and never while the retry slot still holds a request of that thread. They also assume fe_tid is a real thread. The random stimulus meets this by drawing responses from the bench's own record of accepted requests. It sometimes corrupts the echoed generation, or sends a response to a thread that is not waiting, so that R9's discard path is exercised without ever answering a request still in the slot.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef enum logic [1:0] {
    FS_RUN    = 2'd0,
    FS_WRSP   = 2'd1,
    FS_WRETRY = 2'd2,
    FS_SQUASH = 2'd3
  } fstate_t;
endpackage

// File: rtl/ifl_thread.sv
module ifl_thread
  import ifl_pkg::*;
#(
  parameter int AW   = 32,
  parameter int GENW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            squash_i,
  input  logic [AW-1:0]   line_i,
  input  logic            issue_i,
  input  logic            refused_i,
  input  logic            accepted_i,
  input  logic            rsp_i,
  input  logic [GENW-1:0] rsp_gen_i,
  output fstate_t         state_o,
  output logic [GENW-1:0] gen_o,
  output logic            bvalid_o,
  output logic            hit_o
);
  fstate_t         state_q;
  logic [GENW-1:0] gen_q;
  logic            bvalid_q;
  logic [AW-1:0]   btag_q;
  logic            rsp_match;

  assign rsp_match = rsp_i && (state_q == FS_WRSP) && (rsp_gen_i == gen_q);
  assign hit_o     = bvalid_q && (btag_q == line_i);
  assign state_o   = state_q;
  assign gen_o     = gen_q;
  assign bvalid_o  = bvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= FS_RUN;
      gen_q    <= '0;
      bvalid_q <= 1'b0;
    end else if (squash_i) begin
      state_q <= FS_SQUASH;
      if (state_q != FS_SQUASH) gen_q <= gen_q + 1'b1;
    end else if (rsp_match) begin
      bvalid_q <= 1'b1;
      state_q  <= FS_RUN;
    end else if (issue_i) begin
      btag_q   <= line_i;
      bvalid_q <= 1'b0;
      state_q  <= FS_WRSP;
    end else if (refused_i) begin
      state_q <= FS_WRETRY;
    end else if (accepted_i) begin
      state_q <= FS_WRSP;
    end else if (state_q == FS_SQUASH) begin
      state_q <= FS_RUN;
    end
  end

  a_r8_squash_enters: assert property (@(posedge clk) disable iff (rst)
    squash_i |=> state_o == FS_SQUASH);
  a_r4_issue_waits: assert property (@(posedge clk) disable iff (rst)
    issue_i && !squash_i |=> !bvalid_o && state_o == FS_WRSP);
  a_r9_stale_dropped: assert property (@(posedge clk) disable iff (rst)
    rsp_i && !(state_o == FS_WRSP && rsp_gen_i == gen_o) && !issue_i |=> bvalid_o == $past(bvalid_o));
endmodule

// File: rtl/ifl_retry_slot.sv
module ifl_retry_slot #(
  parameter int AW   = 32,
  parameter int TIDW = 1,
  parameter int GENW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kill_i,
  input  logic            ready_i,
  input  logic            load_i,
  input  logic [AW-1:0]   load_addr_i,
  input  logic [TIDW-1:0] load_tid_i,
  input  logic [GENW-1:0] load_gen_i,
  output logic            valid_o,
  output logic [AW-1:0]   addr_o,
  output logic [TIDW-1:0] tid_o,
  output logic [GENW-1:0] gen_o,
  output logic            blocked_o,
  output logic            refused_o,
  output logic            accepted_o
);
  logic            valid_q, blocked_q;
  logic [AW-1:0]   addr_q;
  logic [TIDW-1:0] tid_q;
  logic [GENW-1:0] gen_q;

  assign refused_o  = valid_q && !ready_i && !kill_i;
  assign accepted_o = valid_q && ready_i && !kill_i;
  assign valid_o    = valid_q;
  assign blocked_o  = blocked_q;
  assign addr_o     = addr_q;
  assign tid_o      = tid_q;
  assign gen_o      = gen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      blocked_q <= 1'b0;
      addr_q    <= '0;
      tid_q     <= '0;
      gen_q     <= '0;
    end else begin
      if (valid_q && (kill_i || ready_i)) begin
        valid_q   <= 1'b0;
        blocked_q <= 1'b0;
      end else if (valid_q) begin
        blocked_q <= 1'b1;
      end
      if (load_i) begin
        valid_q <= 1'b1;
        addr_q  <= load_addr_i;
        tid_q   <= load_tid_i;
        gen_q   <= load_gen_i;
      end
    end
  end

  a_r6_hold_refused: assert property (@(posedge clk) disable iff (rst)
    valid_o && !ready_i && !kill_i |=> valid_o && blocked_o && $stable(addr_o) && $stable(tid_o));
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    valid_o && ready_i && !kill_i && !load_i |=> !valid_o && !blocked_o);
  a_r8_slot_cleared: assert property (@(posedge clk) disable iff (rst)
    valid_o && kill_i && !load_i |=> !valid_o && !blocked_o);
  a_r6_blocked_has_req: assert property (@(posedge clk) disable iff (rst)
    blocked_o |-> valid_o);
endmodule

// File: rtl/ifl_fetch_req.sv
module ifl_fetch_req
  import ifl_pkg::*;
#(
  parameter int NTHR       = 2,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int GENW       = 2,
  localparam int TIDW      = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fe_valid,
  input  logic [TIDW-1:0]   fe_tid,
  input  logic [AW-1:0]     fe_pc,
  input  logic              fe_xlate_fault,
  input  logic              intr_pending,
  input  logic              switched_out,
  input  logic [NTHR-1:0]   squash,
  output logic              req_valid,
  output logic [AW-1:0]     req_addr,
  output logic [TIDW-1:0]   req_tid,
  output logic [GENW-1:0]   req_gen,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [TIDW-1:0]   rsp_tid,
  input  logic [GENW-1:0]   rsp_gen,
  output logic              fe_hit,
  output logic              fe_fault,
  output logic              fe_stall,
  output logic              cache_blocked,
  output logic [2*NTHR-1:0] thr_state,
  output logic [NTHR-1:0]   buf_valid
);
  localparam int OFFW = $clog2(LINE_BYTES);

  fstate_t         t_state [NTHR];
  logic [GENW-1:0] t_gen   [NTHR];
  logic [NTHR-1:0] t_hit, t_bv;
  logic [AW-1:0]   line_addr;
  logic            s_refused, s_accepted, s_kill;
  logic            gate_open, sel_hit, do_issue;

  assign line_addr = {fe_pc[AW-1:OFFW], {OFFW{1'b0}}};
  assign s_kill    = squash[req_tid];

  always_comb begin
    gate_open = fe_valid && (t_state[fe_tid] == FS_RUN) && !squash[fe_tid]
                && !cache_blocked && !switched_out
                && !(intr_pending && (fe_pc[1:0] == 2'b00))
                && !(req_valid && !req_ready);
    sel_hit   = t_hit[fe_tid];
    do_issue  = gate_open && !sel_hit && !fe_xlate_fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fe_hit   <= 1'b0;
      fe_fault <= 1'b0;
      fe_stall <= 1'b0;
    end else begin
      fe_hit   <= gate_open && sel_hit;
      fe_fault <= gate_open && !sel_hit && fe_xlate_fault;
      fe_stall <= fe_valid && !gate_open;
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    ifl_thread #(.AW(AW), .GENW(GENW)) u_thr (
      .clk       (clk),
      .rst       (rst),
      .squash_i  (squash[g]),
      .line_i    (line_addr),
      .issue_i   (do_issue && (fe_tid == TIDW'(g))),
      .refused_i (s_refused && (req_tid == TIDW'(g))),
      .accepted_i(s_accepted && (req_tid == TIDW'(g))),
      .rsp_i     (rsp_valid && (rsp_tid == TIDW'(g))),
      .rsp_gen_i (rsp_gen),
      .state_o   (t_state[g]),
      .gen_o     (t_gen[g]),
      .bvalid_o  (t_bv[g]),
      .hit_o     (t_hit[g])
    );
    assign thr_state[2*g +: 2] = t_state[g];
  end

  assign buf_valid = t_bv;

  ifl_retry_slot #(.AW(AW), .TIDW(TIDW), .GENW(GENW)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .kill_i     (s_kill),
    .ready_i    (req_ready),
    .load_i     (do_issue),
    .load_addr_i(line_addr),
    .load_tid_i (fe_tid),
    .load_gen_i (t_gen[fe_tid]),
    .valid_o    (req_valid),
    .addr_o     (req_addr),
    .tid_o      (req_tid),
    .gen_o      (req_gen),
    .blocked_o  (cache_blocked),
    .refused_o  (s_refused),
    .accepted_o (s_accepted)
  );

  a_r2_intr_hold: assert property (@(posedge clk) disable iff (rst)
    fe_valid && intr_pending && fe_pc[1:0] == 2'b00 |=> fe_stall && !fe_hit && !fe_fault);
  a_r2_switched_hold: assert property (@(posedge clk) disable iff (rst)
    fe_valid && switched_out |=> fe_stall);
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fe_hit, fe_fault, fe_stall}));
  a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_addr[OFFW-1:0] == '0);
endmodule

// File: tb/test_ifl_fetch_req.sv
module test_ifl_fetch_req;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 2, AW = 32, LB = 32, GENW = 2, TIDW = 1;

  logic clk = 0, rst = 1;
  logic fe_valid, fe_xlate_fault, intr_pending, switched_out, req_ready, rsp_valid;
  logic [TIDW-1:0] fe_tid, rsp_tid, req_tid;
  logic [AW-1:0] fe_pc, req_addr;
  logic [NTHR-1:0] squash, buf_valid;
  logic [GENW-1:0] rsp_gen, req_gen;
  logic req_valid, fe_hit, fe_fault, fe_stall, cache_blocked;
  logic [2*NTHR-1:0] thr_state;

  int vectors = 0, errors = 0;

  // bench expectation state
  int m_st [NTHR];
  logic [GENW-1:0] m_gen [NTHR];
  bit m_bv [NTHR];
  logic [AW-1:0] m_tag [NTHR];
  bit m_sv, m_blk, e_hit, e_fault, e_stall;
  logic [AW-1:0] m_sa;
  int m_stid;
  logic [GENW-1:0] m_sg;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifl_fetch_req #(.NTHR(NTHR), .AW(AW), .LINE_BYTES(LB), .GENW(GENW)) i_ifl_fetch_req (
    .clk(clk), .rst(rst), .fe_valid(fe_valid), .fe_tid(fe_tid), .fe_pc(fe_pc),
    .fe_xlate_fault(fe_xlate_fault), .intr_pending(intr_pending), .switched_out(switched_out),
    .squash(squash), .req_valid(req_valid), .req_addr(req_addr), .req_tid(req_tid),
    .req_gen(req_gen), .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_tid(rsp_tid),
    .rsp_gen(rsp_gen), .fe_hit(fe_hit), .fe_fault(fe_fault), .fe_stall(fe_stall),
    .cache_blocked(cache_blocked), .thr_state(thr_state), .buf_valid(buf_valid));

  task automatic chk(string tag, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "req_valid", req_valid, m_sv);
    if (m_sv) begin
      chk(tag, "req_addr", req_addr, m_sa);
      chk(tag, "req_tid", req_tid, m_stid);
      chk(tag, "req_gen", req_gen, m_sg);
    end
    chk(tag, "cache_blocked", cache_blocked, m_blk);
    chk(tag, "fe_hit", fe_hit, e_hit);
    chk(tag, "fe_fault", fe_fault, e_fault);
    chk(tag, "fe_stall", fe_stall, e_stall);
    for (int t = 0; t < NTHR; t++) begin
      chk(tag, "thr_state", thr_state[2*t +: 2], m_st[t]);
      chk(tag, "buf_valid", buf_valid[t], m_bv[t]);
    end
  endtask

  function automatic logic [AW-1:0] align(logic [AW-1:0] a);
    return a & ~(AW'(LB - 1));
  endfunction

  // advance one clock; expectation derived from the requirements
  task automatic cyc(string tag);
    bit open, thit, iss, sqh, refd, accd;
    logic [AW-1:0] line;
    int ft;
    int n_st [NTHR];
    logic [GENW-1:0] n_gen [NTHR];
    bit n_bv [NTHR];
    logic [AW-1:0] n_tag [NTHR];
    bit n_sv, n_blk;
    ft   = int'(fe_tid);
    line = align(fe_pc);
    sqh  = m_sv && squash[m_stid];
    open = fe_valid && m_st[ft] == 0 && !squash[ft] && !m_blk && !switched_out
           && !(intr_pending && fe_pc[1:0] == 2'b00) && !(m_sv && !req_ready);
    thit = m_bv[ft] && m_tag[ft] == line;
    iss  = open && !thit && !fe_xlate_fault;
    refd = m_sv && !req_ready && !sqh;
    accd = m_sv && req_ready && !sqh;
    for (int t = 0; t < NTHR; t++) begin
      n_st[t] = m_st[t]; n_gen[t] = m_gen[t]; n_bv[t] = m_bv[t]; n_tag[t] = m_tag[t];
      if (squash[t]) begin
        n_st[t] = 3;
        if (m_st[t] != 3) n_gen[t] = m_gen[t] + 1'b1;
      end else if (rsp_valid && int'(rsp_tid) == t && m_st[t] == 1 && rsp_gen == m_gen[t]) begin
        n_bv[t] = 1; n_st[t] = 0;
      end else if (iss && ft == t) begin
        n_tag[t] = line; n_bv[t] = 0; n_st[t] = 1;
      end else if (refd && m_stid == t) n_st[t] = 2;
      else if (accd && m_stid == t) n_st[t] = 1;
      else if (m_st[t] == 3) n_st[t] = 0;
    end
    n_sv = m_sv; n_blk = m_blk;
    if (m_sv && (sqh || req_ready)) begin n_sv = 0; n_blk = 0; end
    else if (m_sv) n_blk = 1;
    @(posedge clk); #1;
    e_hit = open && thit; e_fault = open && !thit && fe_xlate_fault; e_stall = fe_valid && !open;
    if (iss) begin n_sv = 1; m_sa = line; m_sg = m_gen[ft]; m_stid = ft; end
    m_sv = n_sv; m_blk = n_blk;
    for (int t = 0; t < NTHR; t++) begin
      m_st[t] = n_st[t]; m_gen[t] = n_gen[t]; m_bv[t] = n_bv[t]; m_tag[t] = n_tag[t];
    end
    compare(tag);
  endtask

  task automatic quiet();
    fe_valid = 0; fe_tid = 0; fe_pc = 0; fe_xlate_fault = 0; intr_pending = 0;
    switched_out = 0; squash = 0; req_ready = 1; rsp_valid = 0; rsp_tid = 0; rsp_gen = 0;
  endtask

  task automatic fetch(int t, logic [AW-1:0] pc, bit flt);
    fe_valid = 1; fe_tid = TIDW'(t); fe_pc = pc; fe_xlate_fault = flt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    quiet();
    for (int t = 0; t < NTHR; t++) begin m_st[t] = 0; m_gen[t] = 0; m_bv[t] = 0; m_tag[t] = 0; end
    m_sv = 0; m_blk = 0; m_sa = 0; m_stid = 0; m_sg = 0; e_hit = 0; e_fault = 0; e_stall = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    compare("R11 reset");

    // R4/R1: miss on thread 0 loads the slot with an aligned address
    fetch(0, 32'h1234, 0); cyc("R4 R1 issue");
    quiet(); cyc("R7 accept");
    // R9: matching response fills the buffer
    rsp_valid = 1; rsp_tid = 0; rsp_gen = 0; cyc("R9 fill");
    quiet();
    fetch(0, 32'h123c, 0); cyc("R3 hit");
    fetch(0, 32'h1241, 1); cyc("R5 fault");
    // R2: interrupt hold only when low bits are zero
    intr_pending = 1; fetch(1, 32'h2000, 0); cyc("R2 intr hold");
    fetch(1, 32'h2002, 0); req_ready = 0; cyc("R2 intr pass");
    intr_pending = 0; fe_valid = 0; cyc("R6 refused");
    fetch(0, 32'h5000, 0); cyc("R2 blocked hold");
    quiet(); cyc("R7 retry accepted");
    // R10: a waiting thread cannot fetch
    fetch(1, 32'h2004, 0); cyc("R10 busy thread");
    quiet(); rsp_valid = 1; rsp_tid = 1; rsp_gen = 2'd3; cyc("R9 wrong gen dropped");
    quiet(); squash = 2'b10; fetch(1, 32'h2004, 0); cyc("R8 R10 squash");
    quiet(); squash = 2'b10; cyc("R8 squash held");
    quiet(); rsp_valid = 1; rsp_tid = 1; rsp_gen = 0; cyc("R8 R9 stale after squash");
    quiet(); cyc("R8 back to run");
    // R8: squash empties a held slot of the same thread
    fetch(0, 32'h3000, 0); req_ready = 0; cyc("R4 issue");
    fe_valid = 0; cyc("R6 refused");
    squash = 2'b01; cyc("R8 slot cleared");
    quiet(); switched_out = 1; fetch(1, 32'h7000, 0); cyc("R2 switched out");
    quiet(); cyc("R8 idle");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int t;
      quiet();
      if ($urandom % 10 < 7)
        fetch($urandom % NTHR, 32'h4000 + (($urandom % 4) * LB) + ($urandom % LB), ($urandom % 10) == 0);
      intr_pending = ($urandom % 10) == 0;
      switched_out = ($urandom % 20) == 0;
      for (int k = 0; k < NTHR; k++) squash[k] = ($urandom % 30) == 0;
      req_ready = ($urandom % 10) < 6;
      t = $urandom % NTHR;
      if (!(m_sv && m_stid == t)) begin
        if (m_st[t] == 1 && ($urandom % 2) == 1) begin
          rsp_valid = 1; rsp_tid = TIDW'(t);
          rsp_gen = (($urandom % 5) == 0) ? m_gen[t] + 1'b1 : m_gen[t];
        end else if (m_st[t] != 1 && ($urandom % 8) == 0) begin
          rsp_valid = 1; rsp_tid = TIDW'(t); rsp_gen = GENW'($urandom);
        end
      end
      cyc("R1-random R3 R4 R6 R7 R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule